// File: doc/BRIEF.md
# Single-Channel DMA Controller with Bus Handshake

This block moves a programmed block of words between one peripheral and memory without the processor touching each word. The processor selects the block with a chip-select and a two-bit register select and, while it owns the bus, writes a start address, a word count and a control word. A start command arms the channel. From then on a request from the peripheral makes the block ask the processor for the bus. Once the grant arrives the block drives the memory address, the read or write strobe and the peripheral acknowledge, moving one word per clock. Data itself flies directly between peripheral and memory; the block only steers the cycle.

The read and write lines have two roles. While the grant is low they are processor strobes into the register file. While the grant is high the processor-side strobes are ignored and the block's own memory strobes take over. When the count runs out the block drops its bus request and raises an interrupt. The interrupt stays up until the processor clears it.

Top module: `dma_ctrl`

## Requirements
- R1: After reset bus_req, irq, dack, rd_o, wr_o, addr_o and dbus_out are all 0, and every register reads 0.
- R2: Register codes on reg_sel are 0 = address, 1 = word count, 2 = control (bit 0 start/run, bit 1 direction), 3 = status (bit 0 done; writing 1 to bit 0 clears it). A write takes effect at the clock edge when csel and wr_i are high and bus_grant is low. A read returns the selected register on dbus_out in the same cycle when csel and rd_i are high and bus_grant is low; otherwise dbus_out is 0.
- R3: No bus request is raised while the run bit is 0, whatever dreq does. Writing the control register with bit 0 = 0 stops the channel.
- R4: With the channel running and dreq high, bus_req is high from the next cycle. Until bus_grant is high, rd_o, wr_o and dack stay low.
- R5: In each granted transfer cycle one word moves. addr_o shows the current address and dack is high. rd_o is high for direction 0 (memory to peripheral) and wr_o is high for direction 1 (peripheral to memory). The address then increments by one and the count decrements by one.
- R6: While bus_grant is low, rd_o, wr_o and dack are low and addr_o is 0. While bus_grant is high, the rd_i and wr_i inputs have no effect on the registers or on dbus_out.
- R7: On the word that brings the count to 0, bus_req is low from the next cycle, irq goes high and no further strobe follows. The address register then reads start+N and the count reads 0.
- R8: If dreq is low during a granted transfer cycle, that word still completes and bus_req is low from the next cycle. Transfers resume when dreq returns.
- R9: irq stays high until the processor writes status with bit 0 = 1.
- R10: Writing start while the count is 0 raises irq at the next cycle without any bus request.
- R11: If the grant is withdrawn mid-block, no word moves and bus_req stays high until the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csel | input | 1 | Processor selects the block |
| reg_sel | input | 2 | Register code |
| rd_i | input | 1 | Processor read strobe, honoured only without grant |
| wr_i | input | 1 | Processor write strobe, honoured only without grant |
| dbus_in | input | DW | Processor write data |
| dbus_out | output | DW | Register read data, 0 when not read |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge to the peripheral during a word |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Bus grant from the processor |
| addr_o | output | AW | Memory address during a word |
| rd_o | output | 1 | Memory read strobe |
| wr_o | output | 1 | Memory write strobe |
| irq | output | 1 | Block-complete interrupt |

## Verification
The word that exhausts the count and a fall of the peripheral request can land in the same cycle. Both then ask for the bus to be released, but only the first should also raise the interrupt. The bench provokes this by dropping dreq exactly on the last granted word of a block. It judges that the word is still counted, that bus_req falls one cycle later with irq high, and that no extra strobe follows. Randomly withdrawn grants and request gaps also put grant loss and request loss against the address and count stepping; these cases are scored against a bench-side address sequence.

// File: rtl/dma_pkg.sv
// Package: shared register codes, control bit positions and sequencer states
// for the DMA controller. Assumes a two-bit register select.
package dma_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STATUS = 2'd3
    } regsel_e;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_TOMEM_BIT = 1;
    localparam int STAT_DONE_BIT  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } dma_state_e;

endpackage

// File: rtl/dma_regs.sv
// Register file: address, count, control and status.
// Assumes host access and word moves never share a cycle: the pin gate only
// allows host access while the grant is low, and words move only under grant.
module dma_regs #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] din,
    input  logic          moving,
    output logic [AW-1:0] addr,
    output logic          run,
    output logic          to_mem,
    output logic          done,
    output logic          cnt_one,
    output logic [DW-1:0] dout
);
    import dma_pkg::*;

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] count;
    regsel_e       sel;

    assign sel     = regsel_e'(reg_sel);
    assign cnt_one = (count == CNT_ONE);

    // Register updates from word moves and from host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            count  <= '0;
            run    <= 1'b0;
            to_mem <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (moving) begin
                addr  <= addr + AW'(1);
                count <= count - CW'(1);
                if (count == CNT_ONE) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
            if (host_wr) begin
                case (sel)
                    SEL_ADDR:  addr  <= din[AW-1:0];
                    SEL_COUNT: count <= din[CW-1:0];
                    SEL_CTRL: begin
                        to_mem <= din[CTRL_TOMEM_BIT];
                        if (din[CTRL_RUN_BIT]) begin
                            if (count == '0) begin
                                done <= 1'b1;
                                run  <= 1'b0;
                            end else begin
                                run <= 1'b1;
                            end
                        end else begin
                            run <= 1'b0;
                        end
                    end
                    SEL_STATUS: begin
                        if (din[STAT_DONE_BIT]) done <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; drives zero when the host is not reading.
    always_comb begin
        dout = '0;
        if (host_rd) begin
            case (sel)
                SEL_ADDR:   dout = DW'(addr);
                SEL_COUNT:  dout = DW'(count);
                SEL_CTRL: begin
                    dout[CTRL_RUN_BIT]   = run;
                    dout[CTRL_TOMEM_BIT] = to_mem;
                end
                SEL_STATUS: dout[STAT_DONE_BIT] = done;
                default:    dout = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_fsm.sv
// Bus handshake sequencer: idle, requesting, transferring.
// Assumes one word per granted clock and that run drops only via the register file.
module dma_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dreq,
    input  logic grant,
    input  logic cnt_one,
    output logic bus_req,
    output logic moving
);
    import dma_pkg::*;

    dma_state_e state, state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state decision from run, request, grant and the last-word flag.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (run && dreq) state_nx = ST_REQ;
            ST_REQ: begin
                if (!run || !dreq) state_nx = ST_IDLE;
                else if (grant)    state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (!grant)       state_nx = run ? ST_REQ : ST_IDLE;
                else if (cnt_one) state_nx = ST_IDLE;
                else if (!dreq)   state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Handshake outputs.
    assign bus_req = (state != ST_IDLE);
    assign moving  = (state == ST_XFER) && grant;

endmodule

// File: rtl/dma_pins.sv
// Pin gate: turns the shared read/write lines into host strobes without grant,
// and into memory strobes plus acknowledge under grant.
// Assumes the grant input is synchronous to clk.
module dma_pins #(
    parameter int AW = 16
) (
    input  logic          grant,
    input  logic          csel,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          moving,
    input  logic          to_mem,
    input  logic [AW-1:0] addr,
    output logic          host_rd,
    output logic          host_wr,
    output logic          rd_o,
    output logic          wr_o,
    output logic          dack,
    output logic [AW-1:0] addr_o
);
    // Host side: only honoured when the processor owns the bus.
    assign host_rd = csel && rd_i && !grant;
    assign host_wr = csel && wr_i && !grant;

    // Memory side: only active during a granted word.
    assign rd_o   = moving && !to_mem;
    assign wr_o   = moving && to_mem;
    assign dack   = moving;
    assign addr_o = moving ? addr : '0;

endmodule

// File: rtl/dma_ctrl.sv
// Top: single-channel DMA controller. Wires the register file, the bus
// sequencer and the pin gate. Assumes AW <= DW and CW <= DW.
module dma_ctrl #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csel,
    input  logic [1:0]    reg_sel,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] dbus_in,
    output logic [DW-1:0] dbus_out,
    input  logic          dreq,
    output logic          dack,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] addr_o,
    output logic          rd_o,
    output logic          wr_o,
    output logic          irq
);
    logic          host_rd, host_wr, moving;
    logic          run, to_mem, done, cnt_one;
    logic [AW-1:0] addr;

    dma_regs #(.AW(AW), .CW(CW), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .reg_sel(reg_sel), .din(dbus_in), .moving(moving), .addr(addr),
        .run(run), .to_mem(to_mem), .done(done), .cnt_one(cnt_one),
        .dout(dbus_out)
    );

    dma_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .run(run), .dreq(dreq), .grant(bus_grant),
        .cnt_one(cnt_one), .bus_req(bus_req), .moving(moving)
    );

    dma_pins #(.AW(AW)) pins_i (
        .grant(bus_grant), .csel(csel), .rd_i(rd_i), .wr_i(wr_i),
        .moving(moving), .to_mem(to_mem), .addr(addr), .host_rd(host_rd),
        .host_wr(host_wr), .rd_o(rd_o), .wr_o(wr_o), .dack(dack),
        .addr_o(addr_o)
    );

    assign irq = done;

endmodule

// File: rtl/dma_ctrl_chk.sv
// Checker for dma_ctrl port behaviour over time; bound to every instance.
module dma_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          csel,
    input logic [1:0]    reg_sel,
    input logic          wr_i,
    input logic [DW-1:0] dbus_in,
    input logic          dreq,
    input logic          dack,
    input logic          bus_req,
    input logic          bus_grant,
    input logic [AW-1:0] addr_o,
    input logic          rd_o,
    input logic          wr_o,
    input logic          irq
);
    logic clear_wr;
    assign clear_wr = csel && wr_i && !bus_grant && (reg_sel == 2'd3) && dbus_in[0];

    // R4
    req_follows_dreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(dreq));

    // R5
    addr_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_o || wr_o) && $past(rd_o || wr_o)) |-> (addr_o == $past(addr_o) + AW'(1)));

    // R5
    strobe_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o || wr_o) |-> (dack && !(rd_o && wr_o)));

    // R6
    no_grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant |-> (!rd_o && !wr_o && !dack));

    // R7
    irq_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !bus_req);

    // R8
    drop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dreq && (rd_o || wr_o)) |=> !bus_req);

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear_wr) |=> irq);

endmodule

bind dma_ctrl dma_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .csel(csel), .reg_sel(reg_sel), .wr_i(wr_i),
    .dbus_in(dbus_in), .dreq(dreq), .dack(dack), .bus_req(bus_req),
    .bus_grant(bus_grant), .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o),
    .irq(irq)
);

// File: tb/dma_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random blocks, scored against a
// bench-side model of the address sequence and the handshake.
module dma_ctrl_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csel = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic          rd_i = 1'b0;
    logic          wr_i = 1'b0;
    logic [DW-1:0] dbus_in = '0;
    logic [DW-1:0] dbus_out;
    logic          dreq = 1'b0;
    logic          dack;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic [AW-1:0] addr_o;
    logic          rd_o;
    logic          wr_o;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    dma_ctrl #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .csel(csel), .reg_sel(reg_sel),
        .rd_i(rd_i), .wr_i(wr_i), .dbus_in(dbus_in), .dbus_out(dbus_out),
        .dreq(dreq), .dack(dack), .bus_req(bus_req), .bus_grant(bus_grant),
        .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input int start, input int k);
        return AW'(start + k);
    endfunction

    task automatic cpu_write(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        csel = 1'b1; wr_i = 1'b1; reg_sel = s; dbus_in = d;
        @(negedge clk);
        csel = 1'b0; wr_i = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] s, output logic [DW-1:0] d);
        @(negedge clk);
        csel = 1'b1; rd_i = 1'b1; reg_sel = s;
        #1 d = dbus_out;
        csel = 1'b0; rd_i = 1'b0;
    endtask

    // One block: program, start, then drive grant/request per cycle and score.
    task automatic run_block(input int start, input int n, input bit to_mem,
                             input int gpct, input int rpct, input int drop_at,
                             input int pre_wait, input bit poke, input string tag);
        int words = 0;
        int hold = 0;
        int drop = drop_at;
        bit last = 0;
        bit fin = 0;
        bit force_g;
        bit stb;
        logic [DW-1:0] rv;
        cpu_write(2'd0, DW'(start));
        cpu_write(2'd1, DW'(n));
        cpu_write(2'd2, {{(DW-2){1'b0}}, to_mem, 1'b1});
        for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
            @(negedge clk);
            if (last) begin
                // R7: released, interrupt up, no further strobe
                chk(irq === 1'b1 && bus_req === 1'b0 && rd_o === 1'b0 && wr_o === 1'b0,
                    {"R7 release ", tag}, {irq, bus_req, rd_o, wr_o}, 4'b1000);
                fin = 1;
                dreq = 1'b0; bus_grant = 1'b0;
                csel = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
            end else begin
                force_g = 0;
                if (cyc < pre_wait) begin
                    dreq = 1'b1;
                end else if (hold > 0) begin
                    // R8: bus released after the request fell
                    chk(bus_req === 1'b0, {"R8 released ", tag}, bus_req, 0);
                    hold--;
                    dreq = 1'b0;
                end else if (drop >= 0 && words == drop && bus_req && bus_grant) begin
                    dreq = 1'b0; hold = 5; drop = -1; force_g = 1;
                end else begin
                    dreq = (($urandom % 100) < rpct);
                end
                if (cyc < pre_wait) bus_grant = 1'b0;
                else bus_grant = bus_req && (force_g || (($urandom % 100) < gpct));
                csel = poke && bus_grant; wr_i = poke && bus_grant; rd_i = poke && bus_grant;
                reg_sel = 2'd0; dbus_in = 16'hDEAD;
                #1;
                stb = rd_o || wr_o;
                if (cyc >= 1 && cyc < pre_wait)
                    // R4: requesting but waiting for grant
                    chk(bus_req === 1'b1 && !stb && dack === 1'b0, {"R4 wait ", tag}, {bus_req, stb}, 2'b10);
                if (force_g)
                    // R8: the word in flight when dreq fell still moves
                    chk(stb, {"R8 in-flight word ", tag}, stb, 1);
                if (!bus_grant)
                    // R6 / R11: no strobes without grant
                    chk(!stb && dack === 1'b0 && addr_o === '0, {"R6 quiet ", tag}, {stb, dack}, 0);
                if (poke && bus_grant)
                    // R6: host read strobe ignored under grant
                    chk(dbus_out === '0, {"R6 no read under grant ", tag}, dbus_out, 0);
                if (stb) begin
                    // R5: address, direction and acknowledge
                    chk(addr_o === exp_addr(start, words), {"R5 address ", tag}, addr_o, exp_addr(start, words));
                    chk(wr_o === to_mem && rd_o === !to_mem && dack === 1'b1,
                        {"R5 direction ", tag}, {wr_o, rd_o, dack}, {to_mem, !to_mem, 1'b1});
                    words++;
                    if (words == n) last = 1;
                end
            end
        end
        chk(fin, {"R7 block finished ", tag}, fin, 1);
        chk(words == n, {"R5 word total ", tag}, words, n);
        cpu_read(2'd0, rv);
        chk(rv === DW'(exp_addr(start, n)), {"R7 final address ", tag}, rv, exp_addr(start, n));
        cpu_read(2'd1, rv);
        chk(rv === '0, {"R7 final count ", tag}, rv, 0);
        repeat (3) @(negedge clk);
        // R9: interrupt held without clear
        chk(irq === 1'b1, {"R9 held ", tag}, irq, 1);
        cpu_write(2'd3, DW'(1));
        #1 chk(irq === 1'b0, {"R9 cleared ", tag}, irq, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [DW-1:0] rv;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bus_req === 0 && irq === 0 && dack === 0 && rd_o === 0 && wr_o === 0 && addr_o === '0 && dbus_out === '0,
            "R1 outputs", {bus_req, irq, dack, rd_o, wr_o}, 0);
        for (int s = 0; s < 4; s++) begin
            cpu_read(2'(s), rv);
            chk(rv === '0, "R1 register zero", rv, 0);
        end

        // R2: register write and readback
        cpu_write(2'd0, 16'h1234);
        cpu_read(2'd0, rv);
        chk(rv === 16'h1234, "R2 address readback", rv, 16'h1234);
        cpu_write(2'd1, 16'h0056);
        cpu_read(2'd1, rv);
        chk(rv === 16'h0056, "R2 count readback", rv, 16'h0056);
        cpu_write(2'd2, 16'h0002);
        cpu_read(2'd2, rv);
        chk(rv === 16'h0002, "R2 control readback", rv, 2);
        @(negedge clk);
        chk(dbus_out === '0, "R2 idle data bus", dbus_out, 0);

        // R3: no request without start, even with dreq high
        dreq = 1'b1;
        repeat (10) @(negedge clk);
        chk(bus_req === 1'b0, "R3 no start no request", bus_req, 0);
        // R3: start then stop before request, then request
        dreq = 1'b0;
        cpu_write(2'd1, 16'd5);
        cpu_write(2'd2, 16'h0001);
        cpu_write(2'd2, 16'h0000);
        dreq = 1'b1;
        repeat (5) @(negedge clk);
        chk(bus_req === 1'b0, "R3 stopped no request", bus_req, 0);
        dreq = 1'b0;

        // R10: start with zero count
        cpu_write(2'd1, 16'd0);
        cpu_write(2'd2, 16'h0001);
        chk(irq === 1'b1 && bus_req === 1'b0, "R10 zero count done", {irq, bus_req}, 2'b10);
        cpu_write(2'd3, 16'h0001);
        chk(irq === 1'b0, "R10 cleared", irq, 0);

        // R4 + R5: wait for grant, then read-direction block
        run_block(16'h0100, 4, 1'b0, 100, 100, -1, 8, 1'b0, "wait-grant");
        // R5 + R6: write-direction block while host pins are poked
        run_block(16'h0200, 5, 1'b1, 100, 100, -1, 0, 1'b1, "poke");
        // R8: request falls mid-block
        run_block(16'h0300, 6, 1'b1, 100, 100, 2, 0, 1'b0, "drop-mid");
        // R7 + R8: request falls on the last word
        run_block(16'h0400, 3, 1'b0, 100, 100, 2, 0, 1'b0, "drop-last");
        // R5: address wraps at the top
        run_block(16'hFFFE, 4, 1'b1, 100, 100, -1, 0, 1'b0, "wrap");
        // R5: single word
        run_block(16'h0010, 1, 1'b0, 100, 100, -1, 0, 1'b0, "single");

        // R11: random grant withdrawals and request gaps
        for (int b = 0; b < 12; b++) begin
            run_block(int'($urandom % 65536), 1 + int'($urandom % 10), 1'($urandom % 2),
                      40 + int'($urandom % 61), 50 + int'($urandom % 51),
                      -1, 0, 1'b0, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule